// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block drives the header of a LIN frame onto a single serial output line. Software loads the header settings and pulses a send command. The block then sends, one bit per bit-time tick, a low break whose length can be set, a high delimiter, and, if selected, the sync byte and the protected identifier byte. Both bytes are sent as standard asynchronous frames: a low start bit, eight data bits LSB first, and a high stop bit. The two parity bits of the identifier can come from software or be computed inside the block.

A busy indication stands for the send-header command bit. It rises when the command is accepted and falls by itself on the tick that ends the last bit of the selected header. The settings are captured when the command is accepted, so software may change them while a header is in progress. A bus monitor compares the level read back from the line with the level being driven. When they differ it sets a sticky bit-error flag, which software clears with a write-one pulse.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset `tx_out` is 1, `hdr_busy` is 0 and `berr_flag` is 0.
- R2: The break is sent as `brk_len`+1 bit times of low level. It starts on the first `bit_tick` after the command is accepted, so the values 0 and 15 give 1 and 16 bits.
- R3: After the break, `tx_out` is high for the delimiter, which lasts `delim_sel`+1 bit times (codes 0, 1, 2, 3 give 1, 2, 3, 4 bits).
- R4: `hdr_sel` chooses what follows the delimiter. Code 0 sends nothing more. Code 1 adds the sync frame: start bit 0, then 0x55 LSB first, then stop bit 1. Code 2 adds the sync frame and then the identifier frame. Code 3 sends nothing, and `hdr_busy` stays 0.
- R5: With `pid_hw_par`=1, bits 0..5 of the identifier byte are `pid_in[5:0]`. Bit 6 is ID0^ID1^ID2^ID4 and bit 7 is the inverse of ID1^ID3^ID4^ID5. The byte is framed like the sync byte.
- R6: With `pid_hw_par`=0, the identifier byte is `pid_in[7:0]` exactly as given, sent LSB first.
- R7: `hdr_busy` is 1 from the clock after an accepted command until the `bit_tick` that ends the last header bit. It then falls to 0 and `tx_out` returns to 1. While `hdr_busy` is 0, `tx_out` is 1.
- R8: A `hdr_go` pulse, or a change of any setting, while `hdr_busy` is 1 has no effect on the header in progress.
- R9: While `hdr_busy` is 1 and `berr_en` is 1, a cycle with `rx_in` different from `tx_out` sets `berr_flag` on the next clock. The flag then holds until a `berr_clr` pulse with no new mismatch.
- R10: `berr_flag` is never set while `berr_en` is 0, and a mismatch while `hdr_busy` is 0 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| hdr_go | input | 1 | Send-header command pulse |
| brk_len | input | 4 | Break length minus one, in bit times |
| delim_sel | input | 2 | Delimiter length code |
| hdr_sel | input | 2 | Header composition code |
| pid_in | input | 8 | Identifier byte, or ID bits 0..5 when hardware parity is on |
| pid_hw_par | input | 1 | Compute identifier parity bits in hardware |
| berr_en | input | 1 | Enable the bit-error monitor |
| berr_clr | input | 1 | Write-one clear of the bit-error flag |
| rx_in | input | 1 | Line level read back from the bus |
| tx_out | output | 1 | Serial line output, idles high |
| hdr_busy | output | 1 | Send-header command bit, clears itself at the end |
| berr_flag | output | 1 | Sticky bit-error flag |

## Verification
The checker watches the per-cycle properties on every clock: the idle-high output, `hdr_busy` and `tx_out` holding between ticks, reserved codes being refused, and the set, hold and enable rules of the error flag. The bench covers what only a full header shows. It compares the bit sequence, tick by tick, against an expected stream built from the settings. This covers break and delimiter lengths at their extremes, each header composition, identifier parity computed in hardware and passed through, and stray commands or setting changes while a header is sent. It also injects line mismatches inside and outside a header.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    // Position of the sequencer inside a header
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ALIGN = 3'd1,
        PH_BREAK = 3'd2,
        PH_DELIM = 3'd3,
        PH_SYNC  = 3'd4,
        PH_PID   = 3'd5
    } hdr_phase_e;

    // Header composition code
    typedef enum logic [1:0] {
        HS_BREAK = 2'd0,
        HS_SYNC  = 2'd1,
        HS_FULL  = 2'd2,
        HS_NONE  = 2'd3
    } hdr_sel_e;

    localparam logic [7:0] SYNC_BYTE  = 8'h55;
    localparam int         FRAME_BITS = 10;

    // Protected identifier: six ID bits plus two parity bits
    function automatic logic [7:0] lin_protect_id(input logic [5:0] id);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    // Start bit at position 0, stop bit at position 9
    function automatic logic [FRAME_BITS-1:0] async_frame(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
    import lin_hdr_pkg::*;
#(
    parameter int BRK_W = 4,
    parameter int DLM_W = 2,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             go,
    input  logic [BRK_W-1:0] brk_len,
    input  logic [DLM_W-1:0] delim_sel,
    input  logic [1:0]       hdr_sel,
    output hdr_phase_e       phase,
    output logic [IDX_W-1:0] idx,
    output logic             accept
);

    hdr_phase_e       phase_q;
    hdr_phase_e       phase_nx;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic [BRK_W-1:0] brk_q;
    logic [DLM_W-1:0] dlm_q;
    hdr_sel_e         sel_q;

    assign accept = (phase_q == PH_IDLE) && go && (hdr_sel_e'(hdr_sel) != HS_NONE);

    // Index of the last bit of the current field
    always_comb begin
        case (phase_q)
            PH_BREAK: last_idx = IDX_W'(brk_q);
            PH_DELIM: last_idx = IDX_W'(dlm_q);
            PH_SYNC,
            PH_PID:   last_idx = IDX_W'(FRAME_BITS - 1);
            default:  last_idx = '0;
        endcase
    end

    // Field that follows the current one
    always_comb begin
        case (phase_q)
            PH_BREAK: phase_nx = PH_DELIM;
            PH_DELIM: phase_nx = (sel_q == HS_BREAK) ? PH_IDLE : PH_SYNC;
            PH_SYNC:  phase_nx = (sel_q == HS_FULL) ? PH_PID : PH_IDLE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            brk_q   <= '0;
            dlm_q   <= '0;
            sel_q   <= HS_BREAK;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q <= PH_ALIGN;
                        idx_q   <= '0;
                        brk_q   <= brk_len;
                        dlm_q   <= delim_sel;
                        sel_q   <= hdr_sel_e'(hdr_sel);
                    end
                end
                PH_ALIGN: begin
                    if (tick) begin
                        phase_q <= PH_BREAK;
                        idx_q   <= '0;
                    end
                end
                default: begin
                    if (tick) begin
                        if (idx_q == last_idx) begin
                            phase_q <= phase_nx;
                            idx_q   <= '0;
                        end else begin
                            idx_q   <= idx_q + IDX_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign phase = phase_q;
    assign idx   = idx_q;

endmodule

// File: rtl/lin_hdr_ser.sv
module lin_hdr_ser
    import lin_hdr_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  hdr_phase_e       phase,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       pid_byte,
    output logic             tx
);

    logic [FRAME_BITS-1:0] frame;
    logic [FRAME_BITS-1:0] shifted;

    always_comb begin
        frame   = (phase == PH_PID) ? async_frame(pid_byte) : async_frame(SYNC_BYTE);
        shifted = frame >> idx;
        case (phase)
            PH_BREAK: tx = 1'b0;
            PH_SYNC,
            PH_PID:   tx = shifted[0];
            default:  tx = 1'b1;
        endcase
    end

endmodule

// File: rtl/lin_bit_mon.sv
module lin_bit_mon (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic active,
    input  logic tx,
    input  logic rx,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    // A new mismatch wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (en && active && (tx != rx)) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
    import lin_hdr_pkg::*;
#(
    parameter int BRK_W = 4,
    parameter int DLM_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             hdr_go,
    input  logic [BRK_W-1:0] brk_len,
    input  logic [DLM_W-1:0] delim_sel,
    input  logic [1:0]       hdr_sel,
    input  logic [7:0]       pid_in,
    input  logic             pid_hw_par,
    input  logic             berr_en,
    input  logic             berr_clr,
    input  logic             rx_in,
    output logic             tx_out,
    output logic             hdr_busy,
    output logic             berr_flag
);

    // Bit index must cover both the longest break and a byte frame
    localparam int IDX_W = (BRK_W > 4) ? BRK_W : 4;

    hdr_phase_e       phase;
    logic [IDX_W-1:0] idx;
    logic             accept;
    logic [7:0]       pid_q;
    logic             tx_bit;

    lin_hdr_seq #(
        .BRK_W(BRK_W),
        .DLM_W(DLM_W),
        .IDX_W(IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (bit_tick),
        .go       (hdr_go),
        .brk_len  (brk_len),
        .delim_sel(delim_sel),
        .hdr_sel  (hdr_sel),
        .phase    (phase),
        .idx      (idx),
        .accept   (accept)
    );

    // Identifier captured once per header
    always_ff @(posedge clk) begin
        if (rst) begin
            pid_q <= '0;
        end else if (accept) begin
            pid_q <= pid_hw_par ? lin_protect_id(pid_in[5:0]) : pid_in;
        end
    end

    lin_hdr_ser #(
        .IDX_W(IDX_W)
    ) u_ser (
        .phase   (phase),
        .idx     (idx),
        .pid_byte(pid_q),
        .tx      (tx_bit)
    );

    assign tx_out   = tx_bit;
    assign hdr_busy = (phase != PH_IDLE);

    lin_bit_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .en    (berr_en),
        .active(hdr_busy),
        .tx    (tx_bit),
        .rx    (rx_in),
        .clr   (berr_clr),
        .flag  (berr_flag)
    );

endmodule

// File: rtl/lin_hdr_tx_chk.sv
module lin_hdr_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_tick,
    input logic       hdr_go,
    input logic [1:0] hdr_sel,
    input logic       berr_en,
    input logic       berr_clr,
    input logic       rx_in,
    input logic       tx_out,
    input logic       hdr_busy,
    input logic       berr_flag
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_out && !hdr_busy && !berr_flag));

    a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
        !hdr_busy |-> tx_out);

    a_r7_busy_ends_on_tick: assert property (@(posedge clk) disable iff (rst)
        (hdr_busy && !bit_tick) |=> hdr_busy);

    a_r2_bit_hold: assert property (@(posedge clk) disable iff (rst)
        (hdr_busy && !bit_tick) |=> $stable(tx_out));

    a_r4_reserved_refused: assert property (@(posedge clk) disable iff (rst)
        (!hdr_busy && hdr_go && hdr_sel == 2'd3) |=> !hdr_busy);

    a_r9_error_sets: assert property (@(posedge clk) disable iff (rst)
        (berr_en && hdr_busy && (rx_in != tx_out)) |=> berr_flag);

    a_r9_error_sticky: assert property (@(posedge clk) disable iff (rst)
        (berr_flag && !berr_clr) |=> berr_flag);

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        (!berr_en && !berr_flag) |=> !berr_flag);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!hdr_busy && !berr_flag) |=> !berr_flag);

endmodule

bind lin_hdr_tx lin_hdr_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .hdr_go   (hdr_go),
    .hdr_sel  (hdr_sel),
    .berr_en  (berr_en),
    .berr_clr (berr_clr),
    .rx_in    (rx_in),
    .tx_out   (tx_out),
    .hdr_busy (hdr_busy),
    .berr_flag(berr_flag)
);

// File: tb/lin_hdr_tx_bench.sv
module lin_hdr_tx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] tick_cnt = 3'd0;
    logic       bit_tick;
    logic       tick_d = 1'b0;
    logic       hdr_go = 1'b0;
    logic [3:0] brk_len = 4'd0;
    logic [1:0] delim_sel = 2'd0;
    logic [1:0] hdr_sel = 2'd0;
    logic [7:0] pid_in = 8'd0;
    logic       pid_hw_par = 1'b0;
    logic       berr_en = 1'b0;
    logic       berr_clr = 1'b0;
    logic       inj = 1'b0;
    logic       rx_in;
    logic       tx_out;
    logic       hdr_busy;
    logic       berr_flag;
    logic       done = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];   // entry = requirement number * 2 + expected bit

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) tick_cnt <= 3'd0;
        else     tick_cnt <= tick_cnt + 3'd1;
        tick_d <= bit_tick;
    end
    assign bit_tick = (tick_cnt == 3'd7);
    assign rx_in    = tx_out ^ inj;

    lin_hdr_tx u_lin_hdr_tx (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .hdr_go(hdr_go),
        .brk_len(brk_len), .delim_sel(delim_sel), .hdr_sel(hdr_sel),
        .pid_in(pid_in), .pid_hw_par(pid_hw_par), .berr_en(berr_en),
        .berr_clr(berr_clr), .rx_in(rx_in), .tx_out(tx_out),
        .hdr_busy(hdr_busy), .berr_flag(berr_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: one expected bit per tick while a header is outstanding
    always @(negedge clk) begin
        if (tick_d && exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            check(tx_out == e[0], $sformatf("R%0d header bit", e >> 1), int'(tx_out), e & 1);
        end
    end

    task automatic push_byte(input logic [7:0] b, input int r);
        exp_q.push_back(r * 2);
        for (int i = 0; i < 8; i++) exp_q.push_back(r * 2 + int'(b[i]));
        exp_q.push_back(r * 2 + 1);
    endtask

    task automatic send(input logic [3:0] bl, input logic [1:0] dl, input logic [1:0] hs,
                        input logic [7:0] pid, input bit hw, input bit disturb);
        logic [7:0] id_byte;
        do @(negedge clk); while (tick_cnt != 3'd3);
        brk_len = bl; delim_sel = dl; hdr_sel = hs; pid_in = pid; pid_hw_par = hw;
        hdr_go = 1'b1;
        if (hs != 2'd3) begin
            for (int i = 0; i <= int'(bl); i++) exp_q.push_back(2 * 2);      // R2 break
            for (int i = 0; i <= int'(dl); i++) exp_q.push_back(3 * 2 + 1);  // R3 delimiter
            if (hs != 2'd0) push_byte(8'h55, 4);                              // R4 sync
            if (hs == 2'd2) begin
                if (hw) begin
                    id_byte[5:0] = pid[5:0];
                    id_byte[6]   = pid[0] ^ pid[1] ^ pid[2] ^ pid[4];
                    id_byte[7]   = ~(pid[1] ^ pid[3] ^ pid[4] ^ pid[5]);
                    push_byte(id_byte, 5);                                    // R5
                end else begin
                    push_byte(pid, 6);                                        // R6
                end
            end
        end
        @(negedge clk);
        hdr_go = 1'b0;
        if (hs == 2'd3) begin
            repeat (20) @(negedge clk);
            check(!hdr_busy && tx_out, "R4 reserved code sends nothing",
                  int'({hdr_busy, tx_out}), 1);
            return;
        end
        check(hdr_busy, "R7 busy after accept", int'(hdr_busy), 1);
        if (disturb) begin
            // R8: new command and new settings mid-header
            repeat (5) @(negedge clk);
            brk_len = ~bl; delim_sel = ~dl; hdr_sel = 2'd2; pid_in = ~pid; pid_hw_par = ~hw;
            hdr_go = 1'b1;
            @(negedge clk);
            hdr_go = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        check(hdr_busy, "R7 busy during last bit", int'(hdr_busy), 1);
        do @(negedge clk); while (!tick_d);
        check(!hdr_busy && tx_out, "R7 busy clears, line idles high",
              int'({hdr_busy, tx_out}), 1);
    endtask

    task automatic inject_at(input int wait_clks, input bit exp_flag, input string req);
        repeat (wait_clks) @(negedge clk);
        inj = 1'b1;
        @(negedge clk);
        inj = 1'b0;
        check(berr_flag == exp_flag, req, int'(berr_flag), int'(exp_flag));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_out && !hdr_busy && !berr_flag, "R1 reset state",
              int'({tx_out, hdr_busy, berr_flag}), 4);

        send(4'd12, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0);   // R2, R3: break only
        send(4'd0,  2'd3, 2'd1, 8'h00, 1'b0, 1'b0);   // R2 shortest break, R3 longest delimiter
        send(4'd15, 2'd1, 2'd2, 8'h3A, 1'b1, 1'b0);   // R2 longest break, R5
        send(4'd5,  2'd2, 2'd2, 8'hC5, 1'b0, 1'b0);   // R6
        send(4'd2,  2'd0, 2'd2, 8'hFF, 1'b1, 1'b0);   // R5 all ones
        send(4'd2,  2'd0, 2'd2, 8'h00, 1'b1, 1'b0);   // R5 all zeros
        send(4'd0,  2'd0, 2'd3, 8'h11, 1'b0, 1'b0);   // R4 reserved
        send(4'd3,  2'd0, 2'd1, 8'h5A, 1'b0, 1'b1);   // R8

        // R9: mismatch inside a header with the monitor enabled
        berr_en = 1'b1;
        fork
            send(4'd9, 2'd1, 2'd1, 8'h00, 1'b0, 1'b0);
            begin
                inject_at(40, 1'b1, "R9 mismatch sets flag");
                repeat (30) @(negedge clk);
                check(berr_flag, "R9 flag sticky", int'(berr_flag), 1);
            end
        join
        berr_clr = 1'b1;
        @(negedge clk);
        berr_clr = 1'b0;
        check(!berr_flag, "R9 write-one clear", int'(berr_flag), 0);

        // R10: mismatch while idle has no effect
        inject_at(3, 1'b0, "R10 idle mismatch ignored");

        // R10: mismatch with the monitor disabled
        berr_en = 1'b0;
        fork
            send(4'd9, 2'd0, 2'd0, 8'h00, 1'b0, 1'b0);
            inject_at(40, 1'b0, "R10 disabled monitor ignores mismatch");
        join
        repeat (5) @(negedge clk);
        check(!berr_flag, "R10 flag still clear", int'(berr_flag), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule